// File: doc/BRIEF.md
# Bidirectional Round Subkey Generator

This block produces the 48-bit round subkeys of a DES-style Feistel cipher, one subkey per round, for a core that computes one round per clock. A 64-bit key is presented together with a load strobe. The block reduces the key to 56 effective bits through the first fixed permuted choice and holds the result as two 28-bit halves. Each advance strobe rotates both halves and moves to the next round. The current subkey is always visible on the output and is formed from the registered halves through the second fixed permuted choice.

A decrypt flag, sampled only when the key is loaded, sets the rotation direction. Encryption rotates the halves to the left. Decryption rotates them to the right. Because the total rotation over sixteen rounds is one full turn of a half, the unrotated permuted key is already the last encryption state. The decryption sequence therefore starts from it and walks backwards. No table of precomputed subkeys is kept. The load and advance strobes are plain single-cycle controls. The subkey output is a level that stays stable until the next strobe, so the consuming round logic needs no handshake.

Top module: `ks_sched_top`

## Requirements
- R1: After reset, and before any load, subkey_o is all zeros.
- R2: Bit numbering: key_i[63] is key bit 1 and key_i[0] is key bit 64. subkey_o[47] is subkey bit 1. With load_i high and decrypt_i low at a clock edge, subkey_o shows round subkey 1 from the next cycle on. For key 0x133457799BBCDFF1, that subkey is 0x1B02EFFC7072.
- R3: In encrypt mode, each advance moves subkey_o to the next round's subkey in the following cycle. The halves rotate left by 1 position at rounds 1, 2, 9 and 16, and by 2 positions at every other round.
- R4: With decrypt_i high at load, subkey_o shows round subkey 16 from the next cycle on. For key 0x133457799BBCDFF1, that subkey is 0xCB3D8B0E17F5. Each following advance yields subkeys 15, 14, … down to 1.
- R5: After the 16th subkey of a sequence, one more advance returns subkey_o to the first subkey of that same mode. This is subkey 1 in encrypt mode and subkey 16 in decrypt mode.
- R6: In a cycle with neither load_i nor adv_i high, subkey_o does not change.
- R7: When load_i and adv_i are high in the same cycle, the load takes effect and the advance is ignored.
- R8: decrypt_i has no effect except in a cycle where load_i is high. Changing it between loads does not alter the rotation direction.
- R9: A load restarts the round count at round 1 in both modes.
- R10: Key bits 8, 16, 24, 32, 40, 48, 56 and 64 (key_i[56], key_i[48], …, key_i[0]) have no effect on any subkey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_i | input | 64 | Cipher key, bit 1 on key_i[63] |
| load_i | input | 1 | Load the key and start at round 1 |
| adv_i | input | 1 | Advance to the next round |
| decrypt_i | input | 1 | Direction select, sampled on load: 1 gives the reversed subkey order |
| subkey_o | output | 48 | Subkey of the current round, bit 1 on subkey_o[47] |

## Verification
On every cycle the assertions check the following. A load restarts the round count. The count wraps from the last round back to the first. Subkey_o holds still when no strobe is present. A rotation never changes the number of ones in a half. Only the bench's scenarios can show that the subkey values are correct. This covers the exact 1-or-2 rotation schedule, the reversed order in decrypt mode, the return to the first subkey after the sixteenth, the ignored parity bits and the fact that the direction is captured only at load. The bench compares full sweeps against a model that applies the cumulative rotation from the raw key, plus a published key/subkey pair.

// File: rtl/ks_sched_pkg.sv
package ks_sched_pkg;

  localparam int KEY_W   = 64;
  localparam int HALF_W  = 28;
  localparam int CD_W    = 2 * HALF_W;
  localparam int SUB_W   = 48;
  localparam int ROUNDS  = 16;
  localparam int RND_W   = $clog2(ROUNDS);

  // First reduction: output position i (bit 1 first) takes key bit PC1_TAB[i]
  localparam int PC1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };

  // Second choice: subkey position i takes bit PC2_TAB[i] of the joined halves
  localparam int PC2_TAB [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  function automatic logic [CD_W-1:0] choice_one(input logic [KEY_W-1:0] k);
    logic [CD_W-1:0] r;
    for (int i = 0; i < CD_W; i++) r[CD_W-1-i] = k[KEY_W-PC1_TAB[i]];
    return r;
  endfunction

  function automatic logic [SUB_W-1:0] choice_two(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] r;
    for (int i = 0; i < SUB_W; i++) r[SUB_W-1-i] = cd[CD_W-PC2_TAB[i]];
    return r;
  endfunction

  // Zero-based encryption round index whose rotation is a single position
  function automatic logic single_step(input logic [RND_W-1:0] idx);
    return (idx == RND_W'(0)) || (idx == RND_W'(1)) ||
           (idx == RND_W'(8)) || (idx == RND_W'(ROUNDS-1));
  endfunction

endpackage

// File: rtl/ks_round_ctl.sv
module ks_round_ctl
  import ks_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic adv_i,
  input  logic decrypt_i,
  output logic dir_right_o,
  output logic step_two_o
);

  logic [RND_W-1:0] round_q;
  logic [RND_W-1:0] round_nxt;
  logic             dir_q;
  logic             at_last;

  assign at_last   = (round_q == RND_W'(ROUNDS-1));
  assign round_nxt = at_last ? '0 : round_q + RND_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_q <= '0;
      dir_q   <= 1'b0;
    end else if (load_i) begin
      round_q <= '0;
      dir_q   <= decrypt_i;
    end else if (adv_i) begin
      round_q <= round_nxt;
    end
  end

  // Encrypt: the step belongs to the round being entered.
  // Decrypt: undo the step of the mirrored encryption round.
  logic [RND_W-1:0] mirror_idx;
  assign mirror_idx  = RND_W'(ROUNDS-1) - round_q;
  assign dir_right_o = dir_q;
  assign step_two_o  = dir_q ? !single_step(mirror_idx) : !single_step(round_nxt);

  // R9
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (round_q == '0));

  // R5
  round_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && at_last) |=> (round_q == '0));

  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(dir_q));

endmodule

// File: rtl/ks_half_rot.sv
module ks_half_rot #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic         right_i,
  input  logic         two_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;
  logic [W-1:0] turned;
  logic [W-1:0] nxt;

  always_comb begin
    unique case ({right_i, two_i})
      2'b00:   turned = {q[W-2:0], q[W-1]};
      2'b01:   turned = {q[W-3:0], q[W-1:W-2]};
      2'b10:   turned = {q[0], q[W-1:1]};
      default: turned = {q[1:0], q[W-1:2]};
    endcase
  end

  always_comb begin
    if (load_i)     nxt = seed_i;
    else if (adv_i) nxt = turned;
    else            nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign q_o = q;

  // R3
  weight_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> ($countones(q) == $past($countones(q))));

endmodule

// File: rtl/ks_sched_top.sv
module ks_sched_top
  import ks_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             decrypt_i,
  output logic [SUB_W-1:0] subkey_o
);

  logic [CD_W-1:0] reduced;
  logic [CD_W-1:0] seed;
  logic [CD_W-1:0] cd;
  logic            dir_right;
  logic            step_two;

  assign reduced = choice_one(key_i);

  ks_round_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .adv_i       (adv_i),
    .decrypt_i   (decrypt_i),
    .dir_right_o (dir_right),
    .step_two_o  (step_two)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] raw;
    assign raw = reduced[h*HALF_W +: HALF_W];
    // Encrypt starts with round 1's single left step folded in;
    // decrypt starts on the unrotated value, equal to the round 16 state.
    assign seed[h*HALF_W +: HALF_W] = decrypt_i ? raw : {raw[HALF_W-2:0], raw[HALF_W-1]};

    ks_half_rot #(.W(HALF_W)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .adv_i   (adv_i),
      .right_i (dir_right),
      .two_i   (step_two),
      .seed_i  (seed[h*HALF_W +: HALF_W]),
      .q_o     (cd[h*HALF_W +: HALF_W])
    );
  end

  assign subkey_o = choice_two(cd);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(subkey_o));

endmodule

// File: tb/ks_sched_top_tb.sv
module ks_sched_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KNOWN_KEY = 64'h133457799BBCDFF1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] key_i = '0;
  logic        load_i = 1'b0;
  logic        adv_i = 1'b0;
  logic        decrypt_i = 1'b0;
  logic [47:0] subkey_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ks_sched_top u_dut (
    .clk(clk), .rst_n(rst_n), .key_i(key_i), .load_i(load_i),
    .adv_i(adv_i), .decrypt_i(decrypt_i), .subkey_o(subkey_o)
  );

  localparam int P1 [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };
  localparam int P2 [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  // Model: subkey n from the raw key via the cumulative left rotation
  function automatic logic [47:0] ref_sub(input logic [63:0] k, input int n);
    logic [55:0] p;
    logic [27:0] c;
    logic [27:0] d;
    logic [47:0] r;
    int s;
    for (int i = 0; i < 56; i++) p[55-i] = k[64-P1[i]];
    c = p[55:28];
    d = p[27:0];
    s = 0;
    for (int j = 1; j <= n; j++) s += (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
    repeat (s) begin
      c = {c[26:0], c[27]};
      d = {d[26:0], d[27]};
    end
    p = {c, d};
    for (int i = 0; i < 48; i++) r[47-i] = p[56-P2[i]];
    return r;
  endfunction

  task automatic chk(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] k, input logic dec);
    key_i = k; decrypt_i = dec; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_adv();
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", subkey_o, 48'h0);
  endtask

  task automatic t_known();
    do_load(KNOWN_KEY, 1'b0);
    chk("R2 known enc first", subkey_o, 48'h1B02EFFC7072);
    do_load(KNOWN_KEY, 1'b1);
    chk("R4 known dec first", subkey_o, 48'hCB3D8B0E17F5);
  endtask

  task automatic t_enc_sweep(input logic [63:0] k);
    do_load(k, 1'b0);
    chk("R2 enc load", subkey_o, ref_sub(k, 1));
    for (int n = 2; n <= 16; n++) begin
      do_adv();
      chk("R3 enc round", subkey_o, ref_sub(k, n));
    end
    do_adv();
    chk("R5 enc wrap", subkey_o, ref_sub(k, 1));
  endtask

  task automatic t_dec_sweep(input logic [63:0] k);
    do_load(k, 1'b1);
    chk("R4 dec load", subkey_o, ref_sub(k, 16));
    for (int n = 15; n >= 1; n--) begin
      do_adv();
      chk("R4 dec round", subkey_o, ref_sub(k, n));
    end
    do_adv();
    chk("R5 dec wrap", subkey_o, ref_sub(k, 16));
  endtask

  task automatic t_hold(input logic [63:0] k);
    do_load(k, 1'b0);
    do_adv();
    repeat (3) @(negedge clk);
    chk("R6 idle hold", subkey_o, ref_sub(k, 2));
  endtask

  task automatic t_priority(input logic [63:0] k);
    do_load(k, 1'b0);
    do_adv();
    do_adv();
    key_i = k; decrypt_i = 1'b1; load_i = 1'b1; adv_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
    chk("R7 load over adv", subkey_o, ref_sub(k, 16));
    do_adv();
    chk("R9 restart count", subkey_o, ref_sub(k, 15));
  endtask

  task automatic t_mode_latch(input logic [63:0] k);
    do_load(k, 1'b0);
    decrypt_i = 1'b1;
    do_adv();
    chk("R8 dir kept enc", subkey_o, ref_sub(k, 2));
    do_load(k, 1'b1);
    decrypt_i = 1'b0;
    do_adv();
    chk("R8 dir kept dec", subkey_o, ref_sub(k, 15));
  endtask

  task automatic t_parity(input logic [63:0] k);
    logic [47:0] base;
    do_load(k, 1'b0);
    base = subkey_o;
    do_load(k ^ 64'h0101010101010101, 1'b0);
    chk("R10 parity ignored r1", subkey_o, base);
    do_adv();
    chk("R10 parity ignored r2", subkey_o, ref_sub(k, 2));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_enc_sweep(KNOWN_KEY);
    t_enc_sweep(64'h0E329232EA6D0D73);
    t_enc_sweep(64'hFFFFFFFF00000000);
    t_dec_sweep(KNOWN_KEY);
    t_dec_sweep(64'hA5C3F00F12345678);
    t_hold(64'h0123456789ABCDEF);
    t_priority(64'hDEADBEEFCAFEF00D);
    t_mode_latch(64'h1122334455667788);
    t_parity(64'h0F1E2D3C4B5A6978);
    finish_run();
  end

endmodule